// File: doc/BRIEF.md
# Asynchronous Serial Channel with Command Register

This block is one full-duplex asynchronous serial channel that a host sets up over a byte-wide register bus. Configuration registers hold the channel mode, the character length of each direction, the baud selection of each direction, and a miscellaneous register. The miscellaneous register drives the RTS pin and picks when the transmit-ready flag asserts. A write-only command register resets or enables the transmitter and the receiver on their own, so the host can reprogram one direction while the other keeps running.

Each direction has a small FIFO. Each direction also has its own baud generator, which runs at sixteen times the chosen rate from a fixed reference clock. A mode bit turns the channel back on itself: transmitted characters go straight into the receiver and the external pins are left alone. The usual bring-up is: reset transmitter, reset receiver, write the parameters, then enable the transmitter and the receiver.

Top module: `serial_chan`

## Requirements
- R1: Registers 0x0, 0x1, 0x4, 0x5, 0x6, 0x7 and 0xB read back the last value written. A write to 0xC pushes the transmit FIFO and a read of 0xC pops the receive FIFO; a read of 0xC while that FIFO is empty returns 0. A read of 0xD returns status: bit0 receive FIFO not empty, bit1 transmit FIFO full, bit2 framing error, bit3 overrun, bit4 transmitter enabled, bit5 receiver enabled. After reset every register is zero, txd is high, tx_rdy is 1 and rx_rdy is 0.
- R2: Writing 0x0F with 0x00 resets the transmitter, 0x40 resets the receiver, 0x02 enables the transmitter and 0x42 enables the receiver. Any other code changes nothing. A disabled transmitter starts no character.
- R3: A character is one low start bit, then the data bits LSB first, then one high stop bit. Bits [1:0] of 0x4 (transmit) and 0x6 (receive) set the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A received character is zero-extended to 8 bits.
- R4: The low nibble of 0x5 (transmit) and 0x7 (receive) selects the rate: 0x0 is 50 baud, 0xA is 2000 baud, 0xD is 9600 baud, and any other code is 9600 baud. One bit lasts 16*floor(REF_HZ/(16*rate)) clocks.
- R5: The transmitter reset command empties the transmit FIFO, aborts any character in progress with txd high from the next clock, and disables the transmitter.
- R6: The receiver reset command empties the receive FIFO, clears the framing and overrun flags, and disables the receiver. A disabled receiver ignores its input line.
- R7: Each FIFO holds 4 characters. A write to a full transmit FIFO is ignored.
- R8: A character that completes while the receive FIFO is full is dropped and sets the overrun flag. The flag stays set until a receiver reset.
- R9: A low stop bit sets the framing-error flag, which stays set until a receiver reset. The character is still stored.
- R10: Bit 7 of register 0x1 selects local loopback. In loopback the transmitter feeds the receiver, txd stays high and rxd is ignored.
- R11: Bit 4 of 0xB selects the tx_rdy condition: 0 means the transmit FIFO is not full, 1 means it is empty. rx_rdy means the receive FIFO is not empty. Both outputs are registered.
- R12: The rts_out pin follows bit 0 of register 0xB.
- R13: A start bit counts only if the line is still low at mid-bit. A low pulse shorter than half a bit produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the baud reference |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after bus_rd |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| rts_out | output | 1 | RTS pin from the miscellaneous register |
| tx_rdy | output | 1 | Transmit-ready flag |
| rx_rdy | output | 1 | Receive-ready flag |

## Verification
The delicate overlap is a reset command that lands in the same cycle as the transmitter shifting a bit or loading a new character. The bench provokes it by issuing the transmit reset while a zero character is on the wire with loopback off. It then judges the line on the next clock and confirms that the flushed characters never appear. A second overlap is a receiver push that meets a full receive FIFO. Here the drop, the flag and the four surviving bytes are each compared against the bench's queue model.

// File: rtl/serial_chan_pkg.sv
package serial_chan_pkg;
  localparam logic [3:0] A_MODE1 = 4'h0;
  localparam logic [3:0] A_MODE2 = 4'h1;
  localparam logic [3:0] A_TXPAR = 4'h4;
  localparam logic [3:0] A_TXTIM = 4'h5;
  localparam logic [3:0] A_RXPAR = 4'h6;
  localparam logic [3:0] A_RXTIM = 4'h7;
  localparam logic [3:0] A_MISC  = 4'hB;
  localparam logic [3:0] A_DATA  = 4'hC;
  localparam logic [3:0] A_STAT  = 4'hD;
  localparam logic [3:0] A_CMD   = 4'hF;

  localparam logic [7:0] CMD_TX_RST = 8'h00;
  localparam logic [7:0] CMD_RX_RST = 8'h40;
  localparam logic [7:0] CMD_TX_EN  = 8'h02;
  localparam logic [7:0] CMD_RX_EN  = 8'h42;

  localparam logic [3:0] BAUD_50   = 4'h0;
  localparam logic [3:0] BAUD_2000 = 4'hA;

  function automatic int unsigned div_of(input int unsigned ref_hz, input int unsigned rate);
    int unsigned d;
    d = ref_hz / (16 * rate);
    return (d == 0) ? 1 : d;
  endfunction
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> count == $past(count));
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/sc_baud.sv
module sc_baud #(
  parameter int unsigned REF_HZ = 14_745_600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] code,
  output logic       tick
);
  import serial_chan_pkg::*;

  localparam int unsigned D_LOW  = div_of(REF_HZ, 50);
  localparam int unsigned D_MID  = div_of(REF_HZ, 2000);
  localparam int unsigned D_HIGH = div_of(REF_HZ, 9600);
  localparam int CNT_W = $clog2(D_LOW + 1);

  logic [CNT_W-1:0] cnt, lim;

  always_comb begin
    case (code)
      BAUD_50:   lim = CNT_W'(D_LOW - 1);
      BAUD_2000: lim = CNT_W'(D_MID - 1);
      default:   lim = CNT_W'(D_HIGH - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && lim != '0 && $stable(code)) |=> !tick);
endmodule

// File: rtl/sc_tx.sv
module sc_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] len,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_dout,
  output logic       fifo_pop,
  output logic       line
);
  logic       busy;
  logic [7:0] frame, nxt;
  logic [3:0] left, sub, ndata;
  logic       start;

  assign ndata    = 4'(len) + 4'd5;
  assign start    = !busy && en && !fifo_empty && !clr;
  assign fifo_pop = start;

  always_comb begin
    nxt = '1;
    for (int i = 0; i < 8; i++)
      if (i < int'(ndata)) nxt[i] = fifo_dout[i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy  <= 1'b0;
      line  <= 1'b1;
      frame <= '1;
      left  <= '0;
      sub   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        line  <= 1'b0;
        frame <= nxt;
        left  <= ndata + 4'd1;
        sub   <= '0;
      end
    end else if (tick) begin
      sub <= sub + 1'b1;
      if (sub == 4'd15) begin
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          line  <= frame[0];
          frame <= {1'b1, frame[7:1]};
          left  <= left - 1'b1;
        end
      end
    end
  end

  assert_reset_idles_line_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (line && !busy));
  assert_disabled_no_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !en) |=> (!busy && line));
endmodule

// File: rtl/sc_rx.sv
module sc_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] len,
  input  logic       line_in,
  input  logic       fifo_full,
  output logic       push,
  output logic [7:0] pdata,
  output logic       frame_err,
  output logic       overrun
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e  st;
  logic [3:0] sub, idx, ndata;
  logic [7:0] sh;

  assign ndata = 4'(len) + 4'd5;
  assign pdata = sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= S_IDLE;
      sub       <= '0;
      idx       <= '0;
      sh        <= '0;
      push      <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      push <= 1'b0;
      if (push && fifo_full) overrun <= 1'b1;
      case (st)
        S_IDLE: begin
          sub <= '0;
          if (en && !line_in) st <= S_START;
        end
        S_START: if (tick) begin
          sub <= sub + 1'b1;
          if (sub == 4'd7) begin
            if (!line_in) begin
              st  <= S_DATA;
              sub <= '0;
              idx <= '0;
              sh  <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_DATA: if (tick) begin
          sub <= sub + 1'b1;
          if (sub == 4'd15) begin
            sh[idx[2:0]] <= line_in;
            idx <= idx + 1'b1;
            if (idx == ndata - 4'd1) st <= S_STOP;
          end
        end
        default: if (tick) begin
          sub <= sub + 1'b1;
          if (sub == 4'd15) begin
            st   <= S_IDLE;
            push <= 1'b1;
            if (!line_in) frame_err <= 1'b1;
          end
        end
      endcase
    end
  end

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (push && fifo_full && !clr) |=> overrun);
  assert_disabled_stays_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !en) |=> (st == S_IDLE && !push));
endmodule

// File: rtl/serial_chan.sv
module serial_chan #(
  parameter int unsigned REF_HZ     = 14_745_600,
  parameter int          FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rts_out,
  output logic       tx_rdy,
  output logic       rx_rdy
);
  import serial_chan_pkg::*;

  logic [7:0] mode1, mode2, txpar, txtim, rxpar, rxtim, misc;
  logic       tx_en, rx_en;
  logic       cmd_wr, tx_clr, rx_clr;
  logic       tx_push, tx_pop, tx_empty, tx_full;
  logic [7:0] tx_dout;
  logic       rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0] rx_dout, rx_pdata;
  logic       tx_tick, rx_tick, tx_line, rx_line;
  logic       rxd_s1, rxd_s2, frame_err, overrun, loop;

  assign cmd_wr  = bus_wr && (bus_addr == A_CMD);
  assign tx_clr  = cmd_wr && (bus_wdata == CMD_TX_RST);
  assign rx_clr  = cmd_wr && (bus_wdata == CMD_RX_RST);
  assign tx_push = bus_wr && (bus_addr == A_DATA);
  assign rx_pop  = bus_rd && (bus_addr == A_DATA);
  assign loop    = mode2[7];
  assign rx_line = loop ? tx_line : rxd_s2;
  assign txd     = loop ? 1'b1 : tx_line;
  assign rts_out = misc[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode1 <= '0; mode2 <= '0; txpar <= '0; txtim <= '0;
      rxpar <= '0; rxtim <= '0; misc  <= '0;
      tx_en <= 1'b0; rx_en <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE1: mode1 <= bus_wdata;
        A_MODE2: mode2 <= bus_wdata;
        A_TXPAR: txpar <= bus_wdata;
        A_TXTIM: txtim <= bus_wdata;
        A_RXPAR: rxpar <= bus_wdata;
        A_RXTIM: rxtim <= bus_wdata;
        A_MISC:  misc  <= bus_wdata;
        A_CMD: begin
          case (bus_wdata)
            CMD_TX_RST: tx_en <= 1'b0;
            CMD_RX_RST: rx_en <= 1'b0;
            CMD_TX_EN:  tx_en <= 1'b1;
            CMD_RX_EN:  rx_en <= 1'b1;
            default:    ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_rdy    <= 1'b0;
      rx_rdy    <= 1'b0;
      rxd_s1    <= 1'b1;
      rxd_s2    <= 1'b1;
    end else begin
      rxd_s1 <= rxd;
      rxd_s2 <= rxd_s1;
      tx_rdy <= misc[4] ? tx_empty : !tx_full;
      rx_rdy <= !rx_empty;
      if (bus_rd) begin
        case (bus_addr)
          A_MODE1: bus_rdata <= mode1;
          A_MODE2: bus_rdata <= mode2;
          A_TXPAR: bus_rdata <= txpar;
          A_TXTIM: bus_rdata <= txtim;
          A_RXPAR: bus_rdata <= rxpar;
          A_RXTIM: bus_rdata <= rxtim;
          A_MISC:  bus_rdata <= misc;
          A_DATA:  bus_rdata <= rx_empty ? 8'h00 : rx_dout;
          A_STAT:  bus_rdata <= {2'b00, rx_en, tx_en, overrun, frame_err, tx_full, !rx_empty};
          default: bus_rdata <= 8'h00;
        endcase
      end
    end
  end

  sc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .din(bus_wdata),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  sc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push), .din(rx_pdata),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  sc_baud #(.REF_HZ(REF_HZ)) u_tx_baud (
    .clk(clk), .rst(rst), .code(txtim[3:0]), .tick(tx_tick));

  sc_baud #(.REF_HZ(REF_HZ)) u_rx_baud (
    .clk(clk), .rst(rst), .code(rxtim[3:0]), .tick(rx_tick));

  sc_tx u_tx (
    .clk(clk), .rst(rst), .clr(tx_clr), .en(tx_en), .tick(tx_tick),
    .len(txpar[1:0]), .fifo_empty(tx_empty), .fifo_dout(tx_dout),
    .fifo_pop(tx_pop), .line(tx_line));

  sc_rx u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .en(rx_en), .tick(rx_tick),
    .len(rxpar[1:0]), .line_in(rx_line), .fifo_full(rx_full),
    .push(rx_push), .pdata(rx_pdata), .frame_err(frame_err), .overrun(overrun));

  assert_tx_reset_disables_R5: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> (!tx_en && tx_empty));
  assert_rx_reset_clears_R6: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (!rx_en && rx_empty && !overrun && !frame_err));
endmodule

// File: tb/serial_chan_tb.sv
module serial_chan_tb;
  localparam int unsigned REF = 614_400;
  localparam int D96 = 4;
  localparam int D2K = 19;
  localparam int BIT96 = 16 * D96;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd, rts_out, tx_rdy, rx_rdy;

  int errs = 0;
  int checks = 0;
  bit m_tx_en = 0, m_loop = 0, m_rts = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  serial_chan #(.REF_HZ(REF), .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .rts_out(rts_out), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // per-clock reference of the pin-level state
  always @(negedge clk) begin
    if (!rst) begin
      if (!m_tx_en || m_loop) chk("R5/R10 txd idle high", int'(txd), 1);
      chk("R12 rts_out", int'(rts_out), int'(m_rts));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    if (a == 4'hF) begin
      if (d == 8'h00) m_tx_en = 0;
      if (d == 8'h02) m_tx_en = 1;
    end
    if (a == 4'h1) m_loop = d[7];
    if (a == 4'hB) m_rts = d[0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_check(input string req);
    logic [7:0] v;
    while (exp_q.size() > 0) begin
      rd(4'hC, v);
      chk(req, int'(v), int'(exp_q.pop_front()));
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopb);
    rxd = 1'b0; wait_clk(BIT96);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_clk(BIT96); end
    rxd = stopb; wait_clk(BIT96);
    rxd = 1'b1; wait_clk(BIT96);
  endtask

  task automatic low_time(output int n);
    int g;
    g = 0; n = 0;
    while (txd === 1'b1 && g < 20000) begin @(posedge clk); g++; end
    while (txd === 1'b0 && n < 20000) begin @(posedge clk); n++; end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1 reset state
    chk("R1 txd after reset", int'(txd), 1);
    chk("R1 tx_rdy after reset", int'(tx_rdy), 1);
    chk("R1 rx_rdy after reset", int'(rx_rdy), 0);
    rd(4'hD, v); chk("R1 status after reset", int'(v), 0);
    rd(4'h5, v); chk("R1 timing reg after reset", int'(v), 0);

    // R2 bring-up sequence, R1 readback
    wr(4'hF, 8'h00); wr(4'hF, 8'h40);
    wr(4'h0, 8'h07); wr(4'h4, 8'h03); wr(4'h6, 8'h03);
    wr(4'h5, 8'h0D); wr(4'h7, 8'h0D); wr(4'hB, 8'h00);
    wr(4'h1, 8'h80);
    wr(4'hF, 8'h02); wr(4'hF, 8'h42);
    rd(4'h0, v); chk("R1 mode readback", int'(v), 8'h07);
    rd(4'h1, v); chk("R1 mode2 readback", int'(v), 8'h80);
    rd(4'hD, v); chk("R2 both enabled", int'(v), 8'h30);
    wr(4'hF, 8'h55);
    rd(4'hD, v); chk("R2 unknown code ignored", int'(v), 8'h30);

    // R10 loopback with rxd held low, R3 8-bit frames
    rxd = 1'b0;
    wr(4'hC, 8'hA5); exp_q.push_back(8'hA5);
    wr(4'hC, 8'h3C); exp_q.push_back(8'h3C);
    wait_clk(1800);
    chk("R11 rx_rdy with data", int'(rx_rdy), 1);
    drain_check("R10 loopback data");
    wait_clk(2);
    chk("R10 rxd ignored, R11 rx_rdy empty", int'(rx_rdy), 0);
    rxd = 1'b1;
    rd(4'hC, v); chk("R1 empty data read", int'(v), 0);

    // R3 shorter characters
    wr(4'h4, 8'h00); wr(4'h6, 8'h00);
    wr(4'hC, 8'hB5); exp_q.push_back(8'h15);
    wait_clk(900);
    drain_check("R3 5-bit zero extended");
    wr(4'h4, 8'h02); wr(4'h6, 8'h02);
    wr(4'hC, 8'hFF); exp_q.push_back(8'h7F);
    wait_clk(900);
    drain_check("R3 7-bit zero extended");
    wr(4'h4, 8'h03); wr(4'h6, 8'h03);

    // R7 full FIFO and R11 ready modes, R12 rts
    wr(4'hF, 8'h00);
    wr(4'hC, 8'h11); wr(4'hC, 8'h22); wr(4'hC, 8'h33); wr(4'hC, 8'h44); wr(4'hC, 8'h55);
    wait_clk(3);
    chk("R11 tx_rdy not-full mode when full", int'(tx_rdy), 0);
    rd(4'hD, v); chk("R7 tx full status", int'(v[1]), 1);
    wr(4'hB, 8'h11);
    wait_clk(3);
    chk("R11 tx_rdy empty mode, not empty", int'(tx_rdy), 0);
    chk("R12 rts high", int'(rts_out), 1);
    wr(4'hF, 8'h02);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    exp_q.push_back(8'h33); exp_q.push_back(8'h44);
    wait_clk(3400);
    chk("R11 tx_rdy empty mode, empty", int'(tx_rdy), 1);
    drain_check("R7 four stored, fifth dropped");
    wait_clk(2);
    chk("R7 no fifth character", int'(rx_rdy), 0);
    wr(4'hB, 8'h00);

    // R5 flush and abort
    wr(4'hF, 8'h00);
    wr(4'hC, 8'h66); wr(4'hC, 8'h77);
    wr(4'hF, 8'h00); wr(4'hF, 8'h02);
    wait_clk(1500);
    chk("R5 flushed nothing sent", int'(rx_rdy), 0);
    wr(4'h1, 8'h00);
    wr(4'hC, 8'h00);
    wait_clk(200);
    chk("R5 mid character low", int'(txd), 0);
    wr(4'hF, 8'h00);
    chk("R5 aborted line high", int'(txd), 1);
    wait_clk(800);
    chk("R5 line stays idle", int'(txd), 1);

    // R8 overrun, R6 clear
    wr(4'h1, 8'h80);
    wr(4'hF, 8'h40); wr(4'hF, 8'h42); wr(4'hF, 8'h02);
    for (int i = 1; i <= 5; i++) begin
      wr(4'hC, 8'(i));
      if (i < 5) exp_q.push_back(8'(i));
    end
    wait_clk(4000);
    rd(4'hD, v); chk("R8 overrun flag", int'(v[3]), 1);
    drain_check("R8 first four kept");
    wr(4'hF, 8'h40);
    rd(4'hD, v); chk("R6 flags cleared, rx disabled", int'(v & 8'h2D), 0);

    // R9 framing, R6 disabled receiver, R13 glitch
    wr(4'h1, 8'h00);
    send_rx(8'h99, 1'b1);
    wr(4'hF, 8'h42);
    wait_clk(20);
    chk("R6 disabled rx ignored line", int'(rx_rdy), 0);
    send_rx(8'h5A, 1'b0);
    rd(4'hD, v); chk("R9 framing flag", int'(v[2]), 1);
    exp_q.push_back(8'h5A);
    drain_check("R9 character still stored");
    wr(4'hF, 8'h40); wr(4'hF, 8'h42);
    rxd = 1'b0; wait_clk(12); rxd = 1'b1;
    wait_clk(1000);
    chk("R13 glitch rejected", int'(rx_rdy), 0);
    send_rx(8'hC3, 1'b1);
    exp_q.push_back(8'hC3);
    drain_check("R13 external byte received");
    rd(4'hD, v); chk("R9 no framing on good stop", int'(v[2]), 0);

    // R4 bit timing on txd
    wr(4'hF, 8'h02);
    wr(4'hC, 8'h00); low_time(n);
    chk("R4 9600 low time in range", int'(n >= 9*16*D96 - D96 && n <= 9*16*D96 + 1), 1);
    wait_clk(200);
    wr(4'h5, 8'h0A);
    wr(4'hC, 8'h00); low_time(n);
    chk("R4 2000 low time in range", int'(n >= 9*16*D2K - D2K && n <= 9*16*D2K + 1), 1);
    wait_clk(600);
    wr(4'h5, 8'h03);
    wr(4'hC, 8'h00); low_time(n);
    chk("R4 unlisted code is 9600", int'(n >= 9*16*D96 - D96 && n <= 9*16*D96 + 1), 1);
    wait_clk(200);

    // R4 receive at 2000 baud in loopback
    wr(4'h5, 8'h0A); wr(4'h7, 8'h0A); wr(4'h1, 8'h80);
    wr(4'hC, 8'h81); exp_q.push_back(8'h81);
    wait_clk(3600);
    drain_check("R4 loopback at 2000 baud");

    finish_run();
  end
endmodule